// File: doc/BRIEF.md
# Byte-Stream SPI Master Controller

This block is an SPI master that a processor drives through a small 32-bit register window. A control word sets the clock polarity and phase, a three-bit divisor code for the serial clock, the master-mode bit, a four-bit active-low slave-select field, and two bits: one for manual chip select and one for manual start. A separate enable word switches the controller on and off. Software pushes bytes into a transmit FIFO and pops received bytes from a receive FIFO. Both FIFOs are 8 bits wide and 128 entries deep by default.

The shift engine takes one byte at a time from the transmit FIFO. It sends the byte MSB first on the data-out pin while it samples the data-in pin. When the byte is complete, the engine pushes exactly one byte into the receive FIFO. To read a slave without sending data, software writes dummy zero bytes. In automatic mode, shifting begins as soon as the controller is enabled, set to master mode, and holding queued data. In manual-start mode, the queued bytes wait for a start pulse. Interrupt handling lives in a separate block. This block only exposes the raw status bits.

Register offsets:
- 0x00: control
- 0x04: status
- 0x14: enable
- 0x1C: transmit data
- 0x20: receive data

Every other offset reads as zero and ignores writes.

Top module: `spim_ctrl`

## Requirements
- R1: After reset:
  - the control word reads 0x0000_3C00 (select field all ones, every other bit 0);
  - ss_n is 4'hF and sclk is 0;
  - status reads 0x01. Status bits are: 0 TX empty, 1 TX full, 2 RX not empty, 3 RX full, 4 RX overflow, 5 busy.
- R2: Each byte written to the transmit port is shifted out MSB first, and the byte sampled on miso is returned in order through the receive port. A loopback of mosi to miso gives back every written byte in all four CPOL/CPHA combinations. Control bit 1 is CPOL and bit 2 is CPHA. With CPHA 0, data is sampled on the first clock edge of each bit; with CPHA 1, on the second edge.
- R3: With divisor code c in control bits 5:3, each sclk half period lasts 2^c reference clock cycles. Code 0 divides the reference clock by 2 and code 7 divides it by 256.
- R4: While no byte is being shifted, sclk rests at the CPOL level.
- R5: When manual chip select (control bit 14) is 1, ss_n follows the select field (control bits 13:10) at all times. When it is 0, ss_n is 4'hF while idle and equals the field while a byte is shifted.
- R6: Shifting begins on its own only when enable-register bit 0 is 1, control bit 0 (master) is 1, and the transmit FIFO holds data. With either bit at 0, queued bytes stay in the FIFO.
- R7: With manual start (control bit 15) set to 1, queued bytes wait until a start_pulse. A single pulse then sends every byte that is queued.
- R8: Clearing the enable bit during a byte lets that byte finish and be received. No further byte starts, and sclk returns to the CPOL level.
- R9: A write to the transmit port while the transmit FIFO holds 128 bytes is dropped.
- R10: A byte received while the receive FIFO is full is discarded and sets status bit 4. The bit stays set until software writes status with bit 4 = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| start_pulse | input | 1 | Start request used in manual-start mode |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 4 | Active-low slave selects |

## Verification
The hardest state to reach from the ports is a full receive FIFO at the moment another byte completes. That condition exists only after 128 bytes have been shifted and none read back. The bench reaches it by writing 129 bytes at the fastest divisor while the engine drains the transmit side, then checks the overflow flag, that the oldest data survives, and that the flag clears. Stopping in the middle of a byte needs a slow divisor so the disable lands inside a transfer. The bench then confirms through the receive port and status that exactly one byte completed.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_STAT = 8'h04;
  localparam logic [7:0] A_ENAB = 8'h14;
  localparam logic [7:0] A_TXD  = 8'h1C;
  localparam logic [7:0] A_RXD  = 8'h20;

  localparam int ST_TXE  = 0;
  localparam int ST_TXF  = 1;
  localparam int ST_RXNE = 2;
  localparam int ST_RXF  = 3;
  localparam int ST_OVF  = 4;
  localparam int ST_BUSY = 5;

  typedef enum logic {ENG_IDLE, ENG_SHIFT} eng_state_t;

  typedef struct packed {
    logic       mstart;
    logic       mcs;
    logic [3:0] sel;
    logic [2:0] code;
    logic       cpha;
    logic       cpol;
    logic       master;
  } ctrl_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full,
  output logic [AW:0]  count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == (AW+1)'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/spim_engine.sv
module spim_engine
  import spim_pkg::*;
#(
  parameter int W      = 8,
  parameter int CODE_W = 3,
  localparam int CNTW  = (1 << CODE_W) - 1,
  localparam int EDGES = 2 * W,
  localparam int EW    = $clog2(EDGES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [CODE_W-1:0] code,
  input  logic [W-1:0]      tx_byte,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [W-1:0]      rx_byte,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              busy
);
  eng_state_t        state;
  logic [CNTW-1:0]   cnt, half_m1;
  logic [EW-1:0]     edge_n;
  logic [W-1:0]      txsh, rxsh;
  logic              cpha_q;
  logic [CODE_W-1:0] code_q;
  logic              tick, lead, samp;

  assign half_m1 = CNTW'((32'd1 << code_q) - 32'd1);
  assign tick    = (state == ENG_SHIFT) && (cnt == half_m1);
  assign lead    = ~edge_n[0];
  assign samp    = cpha_q ? ~lead : lead;
  assign busy    = (state == ENG_SHIFT);
  assign tx_pop  = (state == ENG_IDLE) && start;
  assign rx_push = tick && (edge_n == EW'(EDGES-1));
  assign rx_byte = cpha_q ? {rxsh[W-2:0], miso} : rxsh;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ENG_IDLE;
      sclk   <= 1'b0;
      mosi   <= 1'b0;
      cnt    <= '0;
      edge_n <= '0;
      txsh   <= '0;
      rxsh   <= '0;
      cpha_q <= 1'b0;
      code_q <= '0;
    end else begin
      case (state)
        ENG_IDLE: begin
          sclk   <= cpol;
          cnt    <= '0;
          edge_n <= '0;
          if (start) begin
            state  <= ENG_SHIFT;
            cpha_q <= cpha;
            code_q <= code;
            if (cpha) begin
              txsh <= tx_byte;
            end else begin
              mosi <= tx_byte[W-1];
              txsh <= {tx_byte[W-2:0], 1'b0};
            end
          end
        end
        ENG_SHIFT: begin
          if (tick) begin
            cnt    <= '0;
            sclk   <= ~sclk;
            edge_n <= edge_n + 1'b1;
            if (samp) begin
              rxsh <= {rxsh[W-2:0], miso};
            end else begin
              mosi <= txsh[W-1];
              txsh <= {txsh[W-2:0], 1'b0};
            end
            if (edge_n == EW'(EDGES-1)) state <= ENG_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int NSEL   = 4,
  localparam int W     = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        start_pulse,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic [3:0]  ss_n
);
  ctrl_t        cfg;
  logic         enable_q, go_q, ovf_q;
  logic         tx_push, tx_pop, tx_empty, tx_full;
  logic         rx_push, rx_pop, rx_empty, rx_full;
  logic [W-1:0] tx_dout, rx_din, rx_dout;
  logic [AW:0]  tx_count, rx_count;
  logic         eng_start, eng_busy;
  logic [31:0]  ctrl_word, stat_word;

  assign tx_push   = reg_wr && (reg_addr == A_TXD);
  assign rx_pop    = reg_rd && (reg_addr == A_RXD) && !rx_empty;
  assign eng_start = enable_q && cfg.master && !tx_empty && (!cfg.mstart || go_q);

  assign ctrl_word = {16'd0, cfg.mstart, cfg.mcs, cfg.sel, 4'd0, cfg.code, cfg.cpha, cfg.cpol, cfg.master};
  assign stat_word = {26'd0, eng_busy, ovf_q, rx_full, !rx_empty, tx_full, tx_empty};

  spim_fifo #(.W(W), .DEPTH(DEPTH)) u_txf (
    .clk(clk), .rst(rst), .push(tx_push), .din(reg_wdata[W-1:0]), .pop(tx_pop),
    .dout(tx_dout), .empty(tx_empty), .full(tx_full), .count(tx_count)
  );

  spim_fifo #(.W(W), .DEPTH(DEPTH)) u_rxf (
    .clk(clk), .rst(rst), .push(rx_push), .din(rx_din), .pop(rx_pop),
    .dout(rx_dout), .empty(rx_empty), .full(rx_full), .count(rx_count)
  );

  spim_engine #(.W(W), .CODE_W(3)) u_eng (
    .clk(clk), .rst(rst), .start(eng_start), .cpol(cfg.cpol), .cpha(cfg.cpha),
    .code(cfg.code), .tx_byte(tx_dout), .tx_pop(tx_pop), .rx_push(rx_push),
    .rx_byte(rx_din), .miso(miso), .sclk(sclk), .mosi(mosi), .busy(eng_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg      <= '{mstart: 1'b0, mcs: 1'b0, sel: '1, code: '0, cpha: 1'b0, cpol: 1'b0, master: 1'b0};
      enable_q <= 1'b0;
      ovf_q    <= 1'b0;
      go_q     <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_CTRL) begin
        cfg.master <= reg_wdata[0];
        cfg.cpol   <= reg_wdata[1];
        cfg.cpha   <= reg_wdata[2];
        cfg.code   <= reg_wdata[5:3];
        cfg.sel    <= reg_wdata[13:10];
        cfg.mcs    <= reg_wdata[14];
        cfg.mstart <= reg_wdata[15];
      end
      if (reg_wr && reg_addr == A_ENAB) enable_q <= reg_wdata[0];
      if (rx_push && rx_full) ovf_q <= 1'b1;
      else if (reg_wr && reg_addr == A_STAT && reg_wdata[ST_OVF]) ovf_q <= 1'b0;
      if (!cfg.mstart)                      go_q <= 1'b0;
      else if (start_pulse)                 go_q <= 1'b1;
      else if (tx_pop && tx_count == 1)     go_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      ss_n      <= '1;
    end else begin
      ss_n <= (cfg.mcs || eng_busy) ? cfg.sel : '1;
      if (reg_rd) begin
        case (reg_addr)
          A_CTRL:  reg_rdata <= ctrl_word;
          A_STAT:  reg_rdata <= stat_word;
          A_ENAB:  reg_rdata <= {31'd0, enable_q};
          A_RXD:   reg_rdata <= rx_empty ? 32'd0 : {24'd0, rx_dout};
          default: reg_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/spim_ctrl_chk.sv
module spim_ctrl_chk #(
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic        clk,
  input logic        rst,
  input logic        sclk,
  input logic        busy,
  input logic        cpol,
  input logic        mstart,
  input logic        go,
  input logic        kick,
  input logic [AW:0] tx_count,
  input logic [AW:0] rx_count
);
  // R4
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy) && $stable(cpol)) |-> (sclk == cpol));

  // R7
  hold_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && mstart && !go && !kick) |=> !busy);

  // R9
  tx_bound_chk: assert property (@(posedge clk) disable iff (rst)
    tx_count <= (AW+1)'(DEPTH));

  // R10
  rx_bound_chk: assert property (@(posedge clk) disable iff (rst)
    rx_count <= (AW+1)'(DEPTH));

  // R2
  rx_step_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_count == $past(rx_count)) || (rx_count == $past(rx_count) + 1'b1) ||
    (rx_count == $past(rx_count) - 1'b1));
endmodule

bind spim_ctrl spim_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .sclk(sclk), .busy(eng_busy), .cpol(cfg.cpol),
  .mstart(cfg.mstart), .go(go_q), .kick(start_pulse),
  .tx_count(tx_count), .rx_count(rx_count)
);

// File: tb/spim_ctrl_tb.sv
`timescale 1ns/1ps
module spim_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr, reg_rd, start_pulse;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        sclk, mosi, miso;
  logic [3:0]  ss_n;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  assign miso = mosi;
  always #5 clk = ~clk;

  spim_ctrl u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .start_pulse(start_pulse),
    .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  // {cpol, cpha, code[2:0], data[7:0]}
  localparam logic [12:0] VEC [6] = '{
    {1'b0, 1'b0, 3'd0, 8'hA5}, {1'b0, 1'b1, 3'd1, 8'h3C},
    {1'b1, 1'b0, 3'd2, 8'h81}, {1'b1, 1'b1, 3'd0, 8'h7E},
    {1'b0, 1'b0, 3'd3, 8'h01}, {1'b1, 1'b1, 3'd2, 8'hF0}
  };

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic idle_wait();
    logic [31:0] s;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 20000; i++) begin
      rd(8'h04, s);
      if (!s[5] && s[0]) break;
    end
  endtask

  function automatic logic [31:0] ctl(bit cpol, bit cpha, int code);
    return {16'd0, 2'b00, 4'hF, 4'd0, 3'(code), cpha, cpol, 1'b1};
  endfunction

  initial begin
    #1500000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] d;
    realtime t1, t2;
    rst = 1'b1; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0; start_pulse = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1
    check("R1 ss_n", ss_n, 4'hF);
    check("R1 sclk", sclk, 0);
    rd(8'h00, d); check("R1 ctrl", d, 32'h3C00);
    rd(8'h04, d); check("R1 status", d, 32'h01);

    wr(8'h14, 1);
    for (int i = 0; i < 6; i++) begin
      logic [12:0] v;
      v = VEC[i];
      wr(8'h00, ctl(v[12], v[11], v[10:8]));
      repeat (3) @(negedge clk);
      // R4
      check("R4 idle level", sclk, v[12]);
      wr(8'h1C, {24'd0, v[7:0]});
      @(sclk); t1 = $realtime;
      @(sclk); t2 = $realtime;
      // R3
      check("R3 half period", int'((t2 - t1) / 10.0), 1 << v[10:8]);
      idle_wait();
      // R2
      rd(8'h20, d); check("R2 loopback", d, v[7:0]);
    end

    // R5 manual and automatic select
    wr(8'h00, {16'd0, 2'b01, 4'hD, 4'd0, 3'd0, 3'b001});
    repeat (2) @(negedge clk);
    check("R5 manual ss", ss_n, 4'hD);
    wr(8'h00, {16'd0, 2'b00, 4'hB, 4'd0, 3'd3, 3'b001});
    repeat (2) @(negedge clk);
    check("R5 auto idle ss", ss_n, 4'hF);
    wr(8'h1C, 32'h55);
    repeat (20) @(negedge clk);
    check("R5 auto active ss", ss_n, 4'hB);
    idle_wait();
    rd(8'h20, d); check("R2 byte 55", d, 8'h55);

    // R6 master bit clear
    wr(8'h00, 32'h3C00);
    wr(8'h1C, 32'h12);
    repeat (60) @(negedge clk);
    rd(8'h04, d); check("R6 no master held", d & 32'h25, 32'h00);
    wr(8'h00, ctl(0, 0, 0));
    idle_wait();
    rd(8'h20, d); check("R6 drained", d, 8'h12);

    // R7 manual start
    wr(8'h00, ctl(0, 0, 0) | 32'h8000);
    wr(8'h1C, 32'hC3);
    wr(8'h1C, 32'h99);
    repeat (80) @(negedge clk);
    rd(8'h04, d); check("R7 held", d & 32'h25, 32'h00);
    @(negedge clk); start_pulse = 1'b1;
    @(negedge clk); start_pulse = 1'b0;
    idle_wait();
    rd(8'h20, d); check("R7 first", d, 8'hC3);
    rd(8'h20, d); check("R7 second", d, 8'h99);

    // R8 disable mid byte
    wr(8'h00, ctl(1, 0, 7));
    wr(8'h1C, 32'h6B);
    wr(8'h1C, 32'h2D);
    repeat (300) @(negedge clk);
    wr(8'h14, 0);
    repeat (4000) @(negedge clk);
    rd(8'h04, d); check("R8 stopped status", d & 32'h25, 32'h04);
    check("R8 sclk idle", sclk, 1);
    rd(8'h20, d); check("R8 finished byte", d, 8'h6B);
    rd(8'h04, d); check("R8 one byte only", d[2], 0);
    wr(8'h00, ctl(0, 0, 0));
    wr(8'h14, 1);
    idle_wait();
    rd(8'h20, d); check("R8 remaining byte", d, 8'h2D);

    // R9 transmit FIFO full
    wr(8'h14, 0);
    for (int i = 0; i < 130; i++) wr(8'h1C, i);
    rd(8'h04, d); check("R9 tx full", d[1], 1);
    wr(8'h14, 1);
    idle_wait();
    for (int i = 0; i < 127; i++) rd(8'h20, d);
    rd(8'h20, d); check("R9 last kept", d, 127);
    rd(8'h04, d); check("R9 nothing more", d & 32'h1C, 32'h00);

    // R10 receive overflow
    for (int i = 0; i < 129; i++) wr(8'h1C, (i + 3) & 8'hFF);
    idle_wait();
    rd(8'h04, d); check("R10 full and overflow", d & 32'h18, 32'h18);
    rd(8'h20, d); check("R10 oldest kept", d, 3);
    wr(8'h04, 32'h10);
    rd(8'h04, d); check("R10 flag cleared", d[4], 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule